// File: doc/BRIEF.md
# Dual-Bundle Slot Dispersal

This block sits between an instruction buffer and the issue ports of a wide in-order core. Each cycle it is offered up to two 128-bit instruction bundles. It reads only the 5-bit template of each bundle, and a four-bit opcode field when the bundle holds a two-slot extended instruction. From these it works out which unit class each of the three slots needs and where the stops fall. It then hands the slots, in program order, to the nine issue ports: two memory (M), two integer (I), two floating-point (F) and three branch (B). Within a class, the lowest-numbered free port is taken first.

Issue ends for the cycle when a slot finds no free port of its class, when a stop is reached, or when a template code is not legal. The buffer then gets back two advance flags and a resume slot index. It uses them to pop finished bundles and to re-present the unfinished one as bundle 0 in the next cycle. Every result is registered, so all outputs appear one clock after the inputs. Decoding what each instruction means, and the execution units themselves, are outside this block.

Top module: `bundle_disperse`

## Requirements
- R1: A bundle carries its template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Template bits [4:1] select the kind and bit 0 places a stop after slot 2. Kind codes: 0 MII, 1 MI-stop-I, 2 MLX, 4 MMI, 5 M-stop-MI, 6 MFI, 7 MMF, 8 MIB, 9 MBB, 11 BBB, 12 MMB, 14 MFB.
- R2: Each slot goes to a port of the class its template letter names. The port numbers are M0=0, M1=1, I0=2, I1=3, F0=4, F1=5, B0=6, B1=7, B2=8, and each lane reports its number in a 4-bit field, with lane L in bits [4L+3:4L].
- R3: Slots are served in program order: bundle 0 slots 0..2 first, then bundle 1 slots 0..2 (lanes 0..5). Each takes the lowest-numbered port of its class that is still free this cycle.
- R4: When a slot finds no free port of its class, that slot and every later slot in both bundles do not issue this cycle.
- R5: A stop ends the issue group. Kind 1 has a stop after slot 1, kind 5 has one after slot 0, and template bit 0 adds one after slot 2. Slots after a stop issue no earlier than the next cycle.
- R6: In kind 2, slots 1 and 2 form one extended instruction that issues on one port, and both lanes report that port. The port is a B port when bits [40:37] of slot 2 equal 4'hC or 4'hD, and an I port otherwise. If the pair cannot get a port, both slots wait.
- R7: Kinds 3, 10, 13 and 15 are illegal. A valid bundle with such a kind raises its bit of the illegal-template output (bit 0 for bundle 0, bit 1 for bundle 1) and issues no slot. An illegal bundle 0 also keeps bundle 1 from issuing.
- R8: Bundle 1 issues only when all remaining slots of bundle 0 issue and no stop follows bundle 0's slot 2. The same-cycle flag is high when any bundle-1 slot issues. A bundle's advance flag is high when all of its pending slots issue.
- R9: The start index gives the first pending slot of bundle 0, so slots below it do not issue. The value 3 means bundle 0 has nothing pending: it counts as advanced and bundle 1 may issue.
- R10: The resume index is the first slot not yet issued: in bundle 0 if it has not advanced, otherwise in bundle 1 if that bundle is valid and has not advanced, otherwise 0. With bundle 0 invalid or illegal it equals the start index.
- R11: A bundle whose valid input is low issues nothing and raises no flag. If bundle 0 is not valid, bundle 1 does not issue.
- R12: Every issued lane carries the 41 bits of its slot on the payload output, lane L in bits [41L+40:41L]. Lanes that do not issue carry zero.
- R13: All outputs are registered and show the result of the inputs one clock after they are applied. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd0_i | input | 128 | Older bundle |
| bnd0_vld_i | input | 1 | Older bundle present |
| bnd0_start_i | input | 2 | First pending slot of the older bundle (3 = none) |
| bnd1_i | input | 128 | Younger bundle |
| bnd1_vld_i | input | 1 | Younger bundle present |
| iss_vld_o | output | 6 | Lane issued, lanes 0..2 older bundle, 3..5 younger |
| iss_port_o | output | 24 | Issue port number per lane, 4 bits each |
| slot_o | output | 246 | Slot payload per lane, 41 bits each |
| b0_adv_o | output | 1 | Older bundle fully issued |
| b1_adv_o | output | 1 | Younger bundle fully issued |
| pair_same_o | output | 1 | Some younger-bundle slot issued this cycle |
| resume_o | output | 2 | Slot index to re-present next cycle |
| bad_tmpl_o | output | 2 | Illegal template per bundle |

## Verification
Every result is due exactly one clock after its inputs are applied, because each output is registered once and no path crosses more than one edge. The driver changes the inputs on a falling edge and pushes the expected item into a queue at that moment. The monitor wakes 5 ns after the next rising edge, pops that one item, and compares every field against it. Issue ports are compared only on lanes expected to issue. Payloads are compared on all lanes, so lanes that stay silent must read zero.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
    localparam int SLOT_W  = 41;
    localparam int TMPL_W  = 5;
    localparam int SLOTS   = 3;
    localparam int BUNDLES = 2;
    localparam int LANES   = SLOTS * BUNDLES;
    localparam int BNDL_W  = TMPL_W + SLOTS * SLOT_W;
    localparam int XOP_W   = 4;

    typedef enum logic [2:0] {CL_M, CL_I, CL_F, CL_B, CL_X} ucls_e;

    typedef enum logic [3:0] {
        K_MII  = 4'd0,  K_MI_I = 4'd1,  K_MLX = 4'd2,  K_MMI = 4'd4,
        K_M_MI = 4'd5,  K_MFI  = 4'd6,  K_MMF = 4'd7,  K_MIB = 4'd8,
        K_MBB  = 4'd9,  K_BBB  = 4'd11, K_MMB = 4'd12, K_MFB = 4'd14
    } kind_e;

    typedef struct packed {
        logic                     legal;
        logic [SLOTS-1:0]         stop_after;
        ucls_e [SLOTS-1:0]        cls;
    } tdec_t;

    function automatic logic is_long_branch(input logic [XOP_W-1:0] op);
        return (op == 4'hC) || (op == 4'hD);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [BNDL_W-1:0] b, input int k);
        return b[TMPL_W + k*SLOT_W +: SLOT_W];
    endfunction
endpackage

// File: rtl/tmpl_decode.sv
module tmpl_decode
    import bdl_pkg::*;
(
    input  logic [TMPL_W-1:0] tmpl_i,
    input  logic [XOP_W-1:0]  xop_i,
    output tdec_t             dec_o
);
    ucls_e long_cls;
    assign long_cls = is_long_branch(xop_i) ? CL_B : CL_I;

    always_comb begin
        dec_o       = '0;
        dec_o.legal = 1'b1;
        unique case (tmpl_i[TMPL_W-1:1])
            K_MII:   dec_o.cls = {CL_I, CL_I, CL_M};
            K_MI_I:  begin dec_o.cls = {CL_I, CL_I, CL_M}; dec_o.stop_after[1] = 1'b1; end
            K_MLX:   dec_o.cls = {CL_X, long_cls, CL_M};
            K_MMI:   dec_o.cls = {CL_I, CL_M, CL_M};
            K_M_MI:  begin dec_o.cls = {CL_I, CL_M, CL_M}; dec_o.stop_after[0] = 1'b1; end
            K_MFI:   dec_o.cls = {CL_I, CL_F, CL_M};
            K_MMF:   dec_o.cls = {CL_F, CL_M, CL_M};
            K_MIB:   dec_o.cls = {CL_B, CL_I, CL_M};
            K_MBB:   dec_o.cls = {CL_B, CL_B, CL_M};
            K_BBB:   dec_o.cls = {CL_B, CL_B, CL_B};
            K_MMB:   dec_o.cls = {CL_B, CL_M, CL_M};
            K_MFB:   dec_o.cls = {CL_B, CL_F, CL_M};
            default: dec_o.legal = 1'b0;
        endcase
        if (dec_o.legal && tmpl_i[0]) dec_o.stop_after[SLOTS-1] = 1'b1;
    end
endmodule

// File: rtl/slot_disperse.sv
module slot_disperse
    import bdl_pkg::*;
#(
    parameter int N_M = 2,
    parameter int N_I = 2,
    parameter int N_F = 2,
    parameter int N_B = 3,
    localparam int N_PORT = N_M + N_I + N_F + N_B,
    localparam int PORT_W = $clog2(N_PORT)
) (
    input  tdec_t                    dec0_i,
    input  tdec_t                    dec1_i,
    input  logic                     v0_i,
    input  logic                     v1_i,
    input  logic [1:0]               start_i,
    output logic [LANES-1:0]         vld_o,
    output logic [LANES*PORT_W-1:0]  port_o,
    output logic                     b0_done_o,
    output logic                     b1_done_o,
    output logic [1:0]               resume_o,
    output logic [1:0]               bad_o
);
    localparam int I_BASE = N_M;
    localparam int F_BASE = N_M + N_I;
    localparam int B_BASE = N_M + N_I + N_F;

    logic              go, take, prev_iss;
    logic [PORT_W-1:0] cm, ci, cf, cb, pt, prev_port;
    tdec_t             d;
    logic [SLOTS-1:0]  below;

    // program-order walk over six lanes, one shared port budget
    always_comb begin
        go        = v0_i && dec0_i.legal;
        cm        = '0;
        ci        = '0;
        cf        = '0;
        cb        = '0;
        prev_iss  = 1'b0;
        prev_port = '0;
        vld_o     = '0;
        port_o    = '0;
        for (int p = 0; p < LANES; p++) begin
            d = (p < SLOTS) ? dec0_i : dec1_i;
            if (p == SLOTS) begin
                go       = go && v1_i && dec1_i.legal;
                prev_iss = 1'b0;
            end
            take = 1'b0;
            pt   = '0;
            if (go && ((p >= SLOTS) || ((p % SLOTS) >= int'(start_i)))) begin
                case (d.cls[p % SLOTS])
                    CL_X: if (prev_iss) begin take = 1'b1; pt = prev_port; end
                    CL_M: if (int'(cm) < N_M) begin
                              take = 1'b1; pt = cm; cm = cm + 1'b1;
                          end
                    CL_I: if (int'(ci) < N_I) begin
                              take = 1'b1; pt = PORT_W'(I_BASE) + ci; ci = ci + 1'b1;
                          end
                    CL_F: if (int'(cf) < N_F) begin
                              take = 1'b1; pt = PORT_W'(F_BASE) + cf; cf = cf + 1'b1;
                          end
                    default: if (int'(cb) < N_B) begin
                              take = 1'b1; pt = PORT_W'(B_BASE) + cb; cb = cb + 1'b1;
                          end
                endcase
                if (!take || d.stop_after[p % SLOTS]) go = 1'b0;
            end
            vld_o[p]                     = take;
            port_o[p*PORT_W +: PORT_W]   = pt;
            prev_iss                     = take;
            prev_port                    = pt;
        end
    end

    always_comb begin
        for (int k = 0; k < SLOTS; k++) below[k] = (k < int'(start_i));
    end

    assign b0_done_o = v0_i && dec0_i.legal && (&(vld_o[SLOTS-1:0] | below));
    assign b1_done_o = v1_i && (&vld_o[LANES-1:SLOTS]);
    assign bad_o     = {v1_i && !dec1_i.legal, v0_i && !dec0_i.legal};

    always_comb begin
        resume_o = '0;
        if (!b0_done_o) begin
            resume_o = start_i;
            for (int k = SLOTS-1; k >= 0; k--)
                if (!below[k] && !vld_o[k]) resume_o = 2'(k);
        end else if (v1_i && !b1_done_o) begin
            for (int k = SLOTS-1; k >= 0; k--)
                if (!vld_o[SLOTS+k]) resume_o = 2'(k);
        end
    end
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
    import bdl_pkg::*;
#(
    parameter int N_M = 2,
    parameter int N_I = 2,
    parameter int N_F = 2,
    parameter int N_B = 3,
    localparam int N_PORT = N_M + N_I + N_F + N_B,
    localparam int PORT_W = $clog2(N_PORT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [BNDL_W-1:0]        bnd0_i,
    input  logic                     bnd0_vld_i,
    input  logic [1:0]               bnd0_start_i,
    input  logic [BNDL_W-1:0]        bnd1_i,
    input  logic                     bnd1_vld_i,
    output logic [LANES-1:0]         iss_vld_o,
    output logic [LANES*PORT_W-1:0]  iss_port_o,
    output logic [LANES*SLOT_W-1:0]  slot_o,
    output logic                     b0_adv_o,
    output logic                     b1_adv_o,
    output logic                     pair_same_o,
    output logic [1:0]               resume_o,
    output logic [1:0]               bad_tmpl_o
);
    logic [BNDL_W-1:0]        bnd [BUNDLES];
    tdec_t                    dec [BUNDLES];
    logic [LANES-1:0]         vld_c;
    logic [LANES*PORT_W-1:0]  port_c;
    logic [LANES*SLOT_W-1:0]  pay_c;
    logic                     b0_done_c, b1_done_c;
    logic [1:0]               resume_c, bad_c;

    assign bnd[0] = bnd0_i;
    assign bnd[1] = bnd1_i;

    for (genvar gb = 0; gb < BUNDLES; gb++) begin : g_dec
        tmpl_decode u_dec (
            .tmpl_i (bnd[gb][TMPL_W-1:0]),
            .xop_i  (bnd[gb][BNDL_W-1 -: XOP_W]),
            .dec_o  (dec[gb])
        );
    end

    slot_disperse #(.N_M(N_M), .N_I(N_I), .N_F(N_F), .N_B(N_B)) u_walk (
        .dec0_i    (dec[0]),
        .dec1_i    (dec[1]),
        .v0_i      (bnd0_vld_i),
        .v1_i      (bnd1_vld_i),
        .start_i   (bnd0_start_i),
        .vld_o     (vld_c),
        .port_o    (port_c),
        .b0_done_o (b0_done_c),
        .b1_done_o (b1_done_c),
        .resume_o  (resume_c),
        .bad_o     (bad_c)
    );

    for (genvar gl = 0; gl < LANES; gl++) begin : g_pay
        assign pay_c[gl*SLOT_W +: SLOT_W] =
            vld_c[gl] ? slot_of(bnd[gl / SLOTS], gl % SLOTS) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_vld_o   <= '0;
            iss_port_o  <= '0;
            slot_o      <= '0;
            b0_adv_o    <= 1'b0;
            b1_adv_o    <= 1'b0;
            pair_same_o <= 1'b0;
            resume_o    <= '0;
            bad_tmpl_o  <= '0;
        end else begin
            iss_vld_o   <= vld_c;
            iss_port_o  <= port_c;
            slot_o      <= pay_c;
            b0_adv_o    <= b0_done_c;
            b1_adv_o    <= b1_done_c;
            pair_same_o <= |vld_c[LANES-1:SLOTS];
            resume_o    <= resume_c;
            bad_tmpl_o  <= bad_c;
        end
    end

    // R8: younger lanes only issue behind a finished older bundle
    a_r8_b1_after_b0: assert property (@(posedge clk) disable iff (rst)
        (|iss_vld_o[LANES-1:SLOTS]) |-> b0_adv_o);
    // R8: a finished younger bundle implies the same-cycle flag
    a_r8_adv_same: assert property (@(posedge clk) disable iff (rst)
        b1_adv_o |-> pair_same_o);
    // R7: illegal older template blocks every lane
    a_r7_bad0_silent: assert property (@(posedge clk) disable iff (rst)
        bad_tmpl_o[0] |-> (iss_vld_o == '0 && !b0_adv_o));
    // R7: illegal younger template blocks its lanes
    a_r7_bad1_silent: assert property (@(posedge clk) disable iff (rst)
        bad_tmpl_o[1] |-> (iss_vld_o[LANES-1:SLOTS] == '0));
    // R13: first cycle after reset shows cleared outputs
    a_r13_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_vld_o == '0 && resume_o == '0 && bad_tmpl_o == '0));

    for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
        // R2: an issued lane names an existing port
        a_r2_port_range: assert property (@(posedge clk) disable iff (rst)
            iss_vld_o[gl] |-> (iss_port_o[gl*PORT_W +: PORT_W] < PORT_W'(N_PORT)));
    end
endmodule

// File: tb/bundle_disperse_tb.sv
module bundle_disperse_tb;
    localparam int KMII = 0, KMI_I = 1, KMLX = 2, KMMI = 4, KM_MI = 5, KMFI = 6;
    localparam int KMMF = 7, KMIB = 8, KMBB = 9, KBBB = 11, KMFB = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] bnd0 = '0, bnd1 = '0;
    logic         v0 = 1'b0, v1 = 1'b0;
    logic [1:0]   st = '0;
    logic [5:0]   iss_vld;
    logic [23:0]  iss_port;
    logic [245:0] slot;
    logic         b0a, b1a, same;
    logic [1:0]   resume, bad;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [127:0] b0, b1;
        logic [5:0]   vld;
        logic [23:0]  port;
        logic         a0, a1, sm;
        logic [1:0]   rs, bd;
        string        tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    bundle_disperse u_dut (
        .clk(clk), .rst(rst),
        .bnd0_i(bnd0), .bnd0_vld_i(v0), .bnd0_start_i(st),
        .bnd1_i(bnd1), .bnd1_vld_i(v1),
        .iss_vld_o(iss_vld), .iss_port_o(iss_port), .slot_o(slot),
        .b0_adv_o(b0a), .b1_adv_o(b1a), .pair_same_o(same),
        .resume_o(resume), .bad_tmpl_o(bad)
    );

    function automatic logic [127:0] mk(input int kind, input logic stp, input logic [3:0] xop);
        logic [127:0] b;
        b          = '0;
        b[4:1]     = 4'(kind);
        b[0]       = stp;
        b[45:5]    = 41'h0_1234_5678 ^ 41'(kind);
        b[86:46]   = 41'h1_0FED_CBA9;
        b[123:87]  = 37'h0_ABCD_1234;
        b[127:124] = xop;
        return b;
    endfunction

    function automatic logic [23:0] pp(input int a0, a1, a2, a3, a4, a5);
        return {4'(a5), 4'(a4), 4'(a3), 4'(a2), 4'(a1), 4'(a0)};
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drv(input logic [127:0] b0, input logic iv0, input logic [1:0] ist,
                       input logic [127:0] b1, input logic iv1,
                       input logic [5:0] ev, input logic [23:0] ep,
                       input logic ea0, input logic ea1, input logic es,
                       input logic [1:0] er, input logic [1:0] eb, input string tag);
        exp_t e;
        @(negedge clk);
        bnd0 = b0; v0 = iv0; st = ist; bnd1 = b1; v1 = iv1;
        e.b0 = b0; e.b1 = b1; e.vld = ev; e.port = ep;
        e.a0 = ea0; e.a1 = ea1; e.sm = es; e.rs = er; e.bd = eb; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: outputs are due one rising edge after the driver's falling edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                logic [245:0] ep;
                e = q.pop_front();
                for (int l = 0; l < 6; l++)
                    ep[l*41 +: 41] = !e.vld[l] ? 41'd0 :
                        (l < 3) ? e.b0[5 + (l % 3)*41 +: 41] : e.b1[5 + (l % 3)*41 +: 41];
                chk(iss_vld == e.vld, e.tag, "iss_vld", 256'(iss_vld), 256'(e.vld));
                for (int l = 0; l < 6; l++)
                    if (e.vld[l])
                        chk(iss_port[l*4 +: 4] == e.port[l*4 +: 4], e.tag, "port",
                            256'(iss_port[l*4 +: 4]), 256'(e.port[l*4 +: 4]));
                chk(slot == ep, {e.tag, " R12"}, "payload", 256'(slot), 256'(ep));
                chk(b0a == e.a0, e.tag, "b0_adv", 256'(b0a), 256'(e.a0));
                chk(b1a == e.a1, e.tag, "b1_adv", 256'(b1a), 256'(e.a1));
                chk(same == e.sm, e.tag, "pair_same", 256'(same), 256'(e.sm));
                chk(resume == e.rs, e.tag, "resume", 256'(resume), 256'(e.rs));
                chk(bad == e.bd, e.tag, "bad_tmpl", 256'(bad), 256'(e.bd));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bnd0 = mk(KMII, 1'b0, 4'h0); v0 = 1'b1; bnd1 = mk(KMII, 1'b0, 4'h0); v1 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset clears everything even with valid inputs present
        chk(iss_vld == '0 && b0a == 0 && b1a == 0 && same == 0 && resume == 0 && bad == 0
            && slot == '0 && iss_port == '0, "R13", "reset state",
            256'({iss_vld, b0a, b1a, same, resume, bad}), 256'(0));
        rst = 1'b0;
        v0 = 1'b0; v1 = 1'b0;

        // R3 R4: I ports run out in bundle 1 slot 2
        drv(mk(KMII,0,0),1,0, mk(KMFI,0,0),1, 6'b011111, pp(0,2,3,1,4,0), 1,0,1, 2,0, "R3/R4 MII+MFI");
        // R4: M ports exhausted at bundle 1 slot 0
        drv(mk(KMMI,0,0),1,0, mk(KMFB,0,0),1, 6'b000111, pp(0,1,2,0,0,0), 1,0,0, 0,0, "R4 MMI+MFB");
        // R2: full dual issue
        drv(mk(KMFI,0,0),1,0, mk(KMIB,0,0),1, 6'b111111, pp(0,4,2,1,3,6), 1,1,1, 0,0, "R2 MFI+MIB");
        // R3: branch ports fill B0..B2 then stall
        drv(mk(KBBB,0,0),1,0, mk(KMBB,0,0),1, 6'b001111, pp(6,7,8,0,0,0), 1,0,1, 1,0, "R3 BBB+MBB");
        // R5: mid-bundle stop after slot 1
        drv(mk(KMI_I,0,0),1,0, mk(KMII,0,0),1, 6'b000011, pp(0,2,0,0,0,0), 0,0,0, 2,0, "R5 MI-stop-I");
        // R9: resume at slot 2
        drv(mk(KMI_I,0,0),1,2, mk(KMFB,0,0),1, 6'b111100, pp(0,0,2,0,4,6), 1,1,1, 0,0, "R9 start2");
        // R5: stop after slot 0
        drv(mk(KM_MI,0,0),1,0, mk(KMII,0,0),1, 6'b000001, pp(0,0,0,0,0,0), 0,0,0, 1,0, "R5 M-stop-MI");
        // R5 R8: end stop blocks bundle 1
        drv(mk(KMMI,1,0),1,0, mk(KMII,0,0),1, 6'b000111, pp(0,1,2,0,0,0), 1,0,0, 0,0, "R5/R8 end stop");
        // R6: long immediate on I, long branch on B
        drv(mk(KMLX,0,4'h0),1,0, mk(KMLX,0,4'hC),1, 6'b111111, pp(0,2,2,1,6,6), 1,1,1, 0,0, "R6 MLX I/B");
        // R6: pair waits together when I ports are gone
        drv(mk(KMII,0,0),1,0, mk(KMLX,0,4'h3),1, 6'b001111, pp(0,2,3,1,0,0), 1,0,1, 1,0, "R6 pair stall");
        // R7: illegal bundle 0
        drv(mk(3,0,0),1,0, mk(KMII,0,0),1, 6'b000000, pp(0,0,0,0,0,0), 0,0,0, 0,2'b01, "R7 bad b0");
        // R7: illegal bundle 1
        drv(mk(KMII,0,0),1,0, mk(13,0,0),1, 6'b000111, pp(0,2,3,0,0,0), 1,0,0, 0,2'b10, "R7 bad b1");
        // R11: bundle 0 not valid (illegal code ignored too)
        drv(mk(15,0,0),0,1, mk(KMII,0,0),1, 6'b000000, pp(0,0,0,0,0,0), 0,0,0, 1,0, "R11 b0 invalid");
        // R11 R10: bundle 1 not valid
        drv(mk(KMII,0,0),1,0, mk(10,0,0),0, 6'b000111, pp(0,2,3,0,0,0), 1,0,0, 0,0, "R11/R10 b1 invalid");
        // R9: start 3 means bundle 0 empty
        drv(mk(KMII,0,0),1,3, mk(KMFB,0,0),1, 6'b111000, pp(0,0,0,0,4,6), 1,1,1, 0,0, "R9 start3");
        // R9 R1: start 1 with MMF behind
        drv(mk(KMFI,0,0),1,1, mk(KMMF,0,0),1, 6'b111110, pp(0,4,2,0,1,5), 1,1,1, 0,0, "R9/R1 start1");

        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule